// File: doc/BRIEF.md
# Memory-Mapped Machine Timer Comparator

This block keeps a 64-bit real-time counter that steps once per tick. A prescaler divides the system clock to make that tick. Next to the counter sits a 64-bit compare value. A level interrupt output is raised once the counter has reached or passed that value. Software reaches both values through a 32-bit register port that spans four word offsets, with the low half at the lower address.

The port moves two 64-bit quantities over a 32-bit bus without tearing. A read of the counter's low word latches all 64 counter bits into a snapshot, and the high-word offset then returns the upper half of that snapshot. A compare update is done in two writes. The low word is first parked in a staging register. The write to the high word then installs the full value in one step and clears the pending interrupt. The new value is then judged against the counter again.

Requests arrive on a valid/ready channel. Each accepted request produces exactly one response on a valid/ready response channel, which can hold one response. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever no response is held, or when the held response leaves in the same cycle (`rsp_ready_i` high). While `rsp_valid_o` is high and `rsp_ready_i` is low, the response data and error flag do not change.

Top module: `mtimer_top`

## Requirements
- R1: While reset is asserted, `timer_irq_o` and `rsp_valid_o` are low and `req_ready_o` is high. The counter, the compare value and the staging word all reset to zero.
- R2: The counter increases by exactly one every `TICK_DIV` clock cycles. The first increment lands on the `TICK_DIV`-th rising edge after reset is released.
- R3: An accepted read of offset 0x0 returns bits 31:0 of the counter value present in the accept cycle. It also stores all 64 counter bits in a snapshot register.
- R4: An accepted read of offset 0x4 returns bits 63:32 of the snapshot taken by the last 0x0 read, not the live counter. After reset the snapshot is zero.
- R5: An accepted write to offset 0x8 stores the word in the staging register only. The active compare value, and so reads of 0x8 and 0xC, are unchanged by it.
- R6: An accepted write to offset 0xC sets the active compare value to {written word, staging word} in one step. Reads of 0x8 and 0xC return bits 31:0 and 63:32 of the active compare value.
- R7: The clock edge that accepts a 0xC write clears the pending bit, so `timer_irq_o` is low in the cycle after that edge.
- R8: The pending bit is set on any clock edge that does not commit a compare value, provided the counter is greater than or equal to the compare value in that cycle. Once set, it stays set until the next commit. `timer_irq_o` is a level copy of the pending bit.
- R9: A write to offset 0x0 or 0x4, or any access to an offset other than 0x0, 0x4, 0x8 or 0xC, gets a response with `rsp_err_o` high and zero data. It changes no counter, snapshot, staging, compare or pending state. Valid accesses respond with `rsp_err_o` low, and write responses carry zero data.
- R10: The response is valid in the cycle after the accepting edge. `req_ready_o` equals (not `rsp_valid_o`) or `rsp_ready_i`. A stalled response holds its data and error flag until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Byte offset within the 16-byte window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken this cycle |
| rsp_rdata_o | output | 32 | Read data; zero for writes and errors |
| rsp_err_o | output | 1 | Access rejected |
| timer_irq_o | output | 1 | Level timer interrupt |

## Verification
A response is due one cycle after the edge that accepts its request. A commit clears the interrupt at that same edge. A compare match raises the interrupt on the next edge, and the counter steps on every `TICK_DIV`-th edge. The bench keeps a cycle-accurate reference of these registers, which it updates at each rising edge from the inputs it drove. It then compares every output at the following falling edge, so each result is checked in the exact cycle it becomes due, including while a response is stalled.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // Byte offsets of the four 32-bit words in the window.
  typedef enum logic [3:0] {
    OFF_CNT_LO = 4'h0,
    OFF_CNT_HI = 4'h4,
    OFF_CMP_LO = 4'h8,
    OFF_CMP_HI = 4'hC
  } mt_off_e;

  // One-hot style decode of a single request.
  typedef struct packed {
    logic rd_cnt_lo;
    logic rd_cnt_hi;
    logic rd_cmp_lo;
    logic rd_cmp_hi;
    logic wr_stage;
    logic wr_commit;
    logic bad;
  } mt_dec_t;

endpackage

// File: rtl/mtimer_tick.sv
module mtimer_tick #(
  parameter int unsigned TICK_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
      end

      assign tick_o = (phase_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [VAL_W-1:0] count_o
);

  logic [VAL_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
  parameter int unsigned BUS_W = 32,
  localparam int unsigned VAL_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stage_we_i,
  input  logic             commit_we_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [VAL_W-1:0] count_i,
  output logic [VAL_W-1:0] cmp_o,
  output logic             pend_o
);

  logic [BUS_W-1:0] stage_q;
  logic [VAL_W-1:0] cmp_q;
  logic             pend_q;
  logic             reached;

  // The low half waits here until the high half arrives.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stage_q <= '0;
    else if (stage_we_i) stage_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cmp_q <= '0;
    else if (commit_we_i) cmp_q <= {wdata_i, stage_q};
  end

  assign reached = (count_i >= cmp_q);

  // A commit wins: it clears, and the next edge re-evaluates.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (commit_we_i) pend_q <= 1'b0;
    else if (reached)     pend_q <= 1'b1;
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/mtimer_port.sv
module mtimer_port
  import mtimer_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  localparam int unsigned VAL_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [3:0]       req_addr_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [BUS_W-1:0] rsp_rdata_o,
  output logic             rsp_err_o,
  input  logic [VAL_W-1:0] count_i,
  input  logic [VAL_W-1:0] cmp_i,
  output logic             stage_we_o,
  output logic             commit_we_o
);

  mt_dec_t          dec;
  logic             accept;
  logic [VAL_W-1:0] snap_q;
  logic [BUS_W-1:0] rd_next;
  logic             rsp_valid_q;
  logic [BUS_W-1:0] rsp_rdata_q;
  logic             rsp_err_q;

  always_comb begin
    dec = '0;
    case (req_addr_i)
      OFF_CNT_LO: if (req_write_i) dec.bad = 1'b1; else dec.rd_cnt_lo = 1'b1;
      OFF_CNT_HI: if (req_write_i) dec.bad = 1'b1; else dec.rd_cnt_hi = 1'b1;
      OFF_CMP_LO: if (req_write_i) dec.wr_stage  = 1'b1; else dec.rd_cmp_lo = 1'b1;
      OFF_CMP_HI: if (req_write_i) dec.wr_commit = 1'b1; else dec.rd_cmp_hi = 1'b1;
      default:    dec.bad = 1'b1;
    endcase
  end

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign stage_we_o  = accept && dec.wr_stage;
  assign commit_we_o = accept && dec.wr_commit;

  // Low-word read freezes the whole counter for the high-word read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   snap_q <= '0;
    else if (accept && dec.rd_cnt_lo) snap_q <= count_i;
  end

  always_comb begin
    rd_next = '0;
    if (dec.rd_cnt_lo) rd_next = count_i[BUS_W-1:0];
    if (dec.rd_cnt_hi) rd_next = snap_q[VAL_W-1:BUS_W];
    if (dec.rd_cmp_lo) rd_next = cmp_i[BUS_W-1:0];
    if (dec.rd_cmp_hi) rd_next = cmp_i[VAL_W-1:BUS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd_next;
      rsp_err_q   <= dec.bad;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top #(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned TICK_DIV = 5,
  localparam int unsigned VAL_W   = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [3:0]       req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [BUS_W-1:0] rsp_rdata_o,
  output logic             rsp_err_o,
  output logic             timer_irq_o
);

  logic             tick;
  logic [VAL_W-1:0] count;
  logic [VAL_W-1:0] cmp;
  logic             stage_we;
  logic             commit_we;

  mtimer_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  mtimer_count #(.VAL_W(VAL_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .count_o(count)
  );

  mtimer_port #(.BUS_W(BUS_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i),
    .rsp_rdata_o(rsp_rdata_o),
    .rsp_err_o  (rsp_err_o),
    .count_i    (count),
    .cmp_i      (cmp),
    .stage_we_o (stage_we),
    .commit_we_o(commit_we)
  );

  mtimer_cmp #(.BUS_W(BUS_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stage_we_i (stage_we),
    .commit_we_i(commit_we),
    .wdata_i    (req_wdata_i),
    .count_i    (count),
    .cmp_o      (cmp),
    .pend_o     (timer_irq_o)
  );

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned VAL_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_write_i,
  input logic [3:0]       req_addr_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [BUS_W-1:0] rsp_rdata_o,
  input logic             rsp_err_o,
  input logic             timer_irq_o,
  input logic [VAL_W-1:0] count_i
);

  logic commit;
  assign commit = req_valid_i && req_ready_o && req_write_i && (req_addr_i == 4'hC);

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_i == $past(count_i)) || (count_i == $past(count_i) + 1'b1));

  // R7
  commit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !timer_irq_o);

  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_irq_o && !commit |=> timer_irq_o);

  // R9
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);

  // R10
  rsp_follows_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o));

endmodule

bind mtimer_top mtimer_chk #(.BUS_W(BUS_W), .VAL_W(VAL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o  (rsp_err_o),
  .timer_irq_o(timer_irq_o),
  .count_i    (count)
);

// File: tb/mtimer_top_tb.sv
module mtimer_top_tb;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned DIV   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, irq;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mtimer_top #(.BUS_W(BUS_W), .TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .timer_irq_o(irq)
  );

  // Reference model built from the requirements.
  int unsigned m_pc;
  logic [63:0] m_cnt, m_cmp, m_snap;
  logic [31:0] m_stage, m_rdata;
  logic m_pend, m_rspv, m_err, m_commit_last;
  string m_tag;

  function automatic logic is_good(input logic wr, input logic [3:0] a);
    return (a == 4'h8 || a == 4'hC) || (!wr && (a == 4'h0 || a == 4'h4));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= 0; m_cnt <= '0; m_cmp <= '0; m_snap <= '0; m_stage <= '0;
      m_pend <= 1'b0; m_rspv <= 1'b0; m_rdata <= '0; m_err <= 1'b0;
      m_commit_last <= 1'b0; m_tag <= "R1";
    end else begin
      logic acc, com;
      acc = req_valid && (!m_rspv || rsp_ready);
      com = acc && req_write && req_addr == 4'hC;
      m_commit_last <= com;
      if (com) m_pend <= 1'b0;                    // R7
      else if (m_cnt >= m_cmp) m_pend <= 1'b1;    // R8
      if (m_pc == DIV - 1) begin m_pc <= 0; m_cnt <= m_cnt + 1; end  // R2
      else m_pc <= m_pc + 1;
      if (acc) begin
        m_rspv <= 1'b1;
        m_err  <= !is_good(req_write, req_addr);
        m_rdata <= '0;
        m_tag  <= "R9";
        if (is_good(req_write, req_addr)) begin
          if (req_write && req_addr == 4'h8) begin m_stage <= req_wdata; m_tag <= "R5"; end
          if (com) begin m_cmp <= {req_wdata, m_stage}; m_tag <= "R6"; end
          if (!req_write) case (req_addr)
            4'h0: begin m_rdata <= m_cnt[31:0]; m_snap <= m_cnt; m_tag <= "R3"; end
            4'h4: begin m_rdata <= m_snap[63:32]; m_tag <= "R4"; end
            4'h8: begin m_rdata <= m_cmp[31:0]; m_tag <= "R6"; end
            default: begin m_rdata <= m_cmp[63:32]; m_tag <= "R6"; end
          endcase
        end
      end else if (rsp_ready) m_rspv <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sampled at the falling edge, before new inputs are driven.
  task automatic check_all();
    chk("R10", "req_ready", 64'(req_ready), 64'(!m_rspv || rsp_ready));
    chk(m_commit_last ? "R7" : "R8", "timer_irq", 64'(irq), 64'(m_pend));
    chk("R10", "rsp_valid", 64'(rsp_valid), 64'(m_rspv));
    if (m_rspv) begin
      chk(m_tag, "rsp_rdata", 64'(rsp_rdata), 64'(m_rdata));
      chk(m_err ? "R9" : m_tag, "rsp_err", 64'(rsp_err), 64'(m_err));
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  task automatic acc_req(input logic wr, input logic [3:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; rsp_ready = 1'b1;
    cyc();
    req_valid = 1'b0;
    cyc();
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: outputs while reset is held
    repeat (3) begin
      @(negedge clk);
      chk("R1", "irq in reset", 64'(irq), 64'd0);
      chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
      chk("R1", "req_ready in reset", 64'(req_ready), 64'd1);
    end
    rst_n = 1'b1;
    cyc();
    // R8: reset compare of zero fires on the first edge
    chk("R8", "irq after reset", 64'(irq), 64'd1);
    // R1/R6: compare reads as zero after reset; R4 snapshot zero
    acc_req(1'b0, 4'h8, 0);
    acc_req(1'b0, 4'hC, 0);
    acc_req(1'b0, 4'h4, 0);
    // R5: staged write leaves compare alone
    acc_req(1'b1, 4'h8, 32'hDEAD_BEEF);
    acc_req(1'b0, 4'h8, 0);
    // R6/R7: commit a far compare, irq must fall and stay low
    acc_req(1'b1, 4'hC, 32'h0000_0001);
    chk("R7", "irq after far commit", 64'(irq), 64'd0);
    acc_req(1'b0, 4'hC, 0);
    // R8: near compare fires later
    acc_req(1'b1, 4'h8, m_cnt[31:0] + 32'd6);
    acc_req(1'b1, 4'hC, 32'd0);
    repeat (60) cyc();
    chk("R8", "irq after counter reached", 64'(irq), 64'd1);
    // R2/R3: counter reads over a gap
    acc_req(1'b0, 4'h0, 0);
    repeat (23) cyc();
    acc_req(1'b0, 4'h0, 0);
    acc_req(1'b0, 4'h4, 0);
    // R9: bad accesses change nothing
    acc_req(1'b1, 4'h0, 32'hFFFF_FFFF);
    acc_req(1'b1, 4'h4, 32'hFFFF_FFFF);
    acc_req(1'b0, 4'h2, 0);
    acc_req(1'b1, 4'hD, 32'h1234_5678);
    acc_req(1'b0, 4'hC, 0);
    acc_req(1'b0, 4'h8, 0);
    // R10: hold a response while stalled
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h0; rsp_ready = 1'b1;
    cyc();
    rsp_ready = 1'b0;
    repeat (6) cyc();
    rsp_ready = 1'b1; req_valid = 1'b0;
    cyc();
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [3:0] a;
      r = $urandom_range(0, 99);
      case ($urandom_range(0, 9))
        0: a = 4'h0; 1: a = 4'h0; 2: a = 4'h4; 3: a = 4'h8; 4: a = 4'h8;
        5: a = 4'hC; 6: a = 4'hC; 7: a = 4'h1; 8: a = 4'hE;
        default: a = 4'($urandom_range(0, 15));
      endcase
      req_valid = (r < 60);
      req_write = $urandom_range(0, 1) == 1;
      req_addr  = a;
      if (a == 4'h8) req_wdata = m_cnt[31:0] + 32'($urandom_range(0, 60)) - 32'd20;
      else if (a == 4'hC) req_wdata = ($urandom_range(0, 7) == 0) ? $urandom() : 32'd0;
      else req_wdata = $urandom();
      rsp_ready = ($urandom_range(0, 3) != 0);
      cyc();
    end
    req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (4) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule